// File: doc/BRIEF.md
# Bit-Serial Destination Ejection Crossbar

This block sits at the output end of a bit-serial routing array. Every bit-time it receives one bit from each of seven message rows. For each row it decides whether the message carried in that row has reached the local node. Messages that have arrived are switched onto one of sixteen processor outputs. All other rows pass through to buffer outputs, so that the injection stage can present them again in the next round.

Each message is sent head first. The first bit is a presence flag. Next come twelve bits of destination address, written relative to the current node. Four processor-select bits follow, and then a payload of any length. A row has arrived when its presence flag is 1 and every relative address bit is zero. This test is done serially while the header streams in. Each row is delayed by the full header length, so the switch is already set when the first bit of the message comes out.

When several arriving rows name the same processor, their bitstreams are ORed together onto that output by default. A single-eject mode lets only one message leave per round, which rules out that merging.

Top module: `ej_eject_xbar`

## Requirements
- R1: While reset is low and in the cycle after it is released, every processor output and every buffer output is 0.
- R2: Every bit offered on a row leaves the block exactly 17 clock cycles after the cycle in which it was presented. The presence bit of a message presented together with `frame_start` appears on the outputs 17 cycles later.
- R3: A row is delivered only if its presence bit is 1 and all 12 address bits that follow are 0. A row with any single address bit set, or with the presence bit at 0, is not delivered.
- R4: The 4 bits after the address, most significant first, give the processor index 0 to 15. A delivered row's whole stream, from the presence bit onward, appears on that processor output. Any row can reach any output.
- R5: When the single-eject mode is off and two or more delivered rows select the same processor, that output carries the bitwise OR of their delayed streams.
- R6: When `one_eject` is 1 in the cycle that presents the last select bit, only the lowest-numbered qualifying row is delivered. All other qualifying rows go to the buffer outputs unchanged.
- R7: A row that is not delivered drives its delayed stream, bit for bit, on its buffer output and on no processor output.
- R8: A delivered row drives 0 on its buffer output for the whole of its message.
- R9: The routing chosen for a message holds until the first bit of the next message leaves the block, including payload bits far past the header. The value of `one_eject` in any other cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-time clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | High in the cycle that carries the presence bits of a new round |
| one_eject | input | 1 | Single-eject mode, sampled with the last select bit |
| row_in | input | 7 | One serial bit per message row |
| proc_out | output | 16 | One serial bit per processor |
| buf_out | output | 7 | One serial bit per row towards the buffers |

## Verification
The hardest case to reach is a round in which merging and single-eject selection interact. Several rows must all pass the twelve-bit zero test and also share a processor index, while the mode input is high in exactly one cycle of the header. Random addresses almost never end up all zero. The stimulus therefore builds each row's address from a mix of all-zero, one-hot and random values, and it draws processor indices from a narrowed range so that rows collide often. Directed rounds then force a full seven-way collision, a single-eject round whose row 0 is empty, and rows that miss arrival by exactly one address bit.

// File: rtl/ej_pkg.sv
`timescale 1ns/1ps
// Package: default geometry of the ejection crossbar and the header length derived from it.
// Assumes the processor count is a power of two.
package ej_pkg;
    localparam int EJ_ROWS   = 7;
    localparam int EJ_PROCS  = 16;
    localparam int EJ_ADDR_W = 12;

    // Header length in bits: presence flag, address, processor select.
    function automatic int hdr_bits(input int addr_w, input int procs);
        return 1 + addr_w + $clog2(procs);
    endfunction
endpackage

// File: rtl/ej_hdr_parse.sv
`timescale 1ns/1ps
// Module: serial header parser for all rows.
// Counts header bit positions from frame_start. For each row it keeps the
// presence flag and a running all-zero test of the address, and it shifts in
// the select bits most significant first. hdr_last marks the cycle that carries
// the final select bit. sel_full already includes that bit.
// Assumes every frame is at least one header long.
module ej_hdr_parse #(
    parameter int ROWS   = 7,
    parameter int ADDR_W = 12,
    parameter int SEL_W  = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           frame_start,
    input  logic [ROWS-1:0]                row_in,
    output logic                           hdr_last,
    output logic [ROWS-1:0]                hit,
    output logic [ROWS-1:0][SEL_W-1:0]     sel_full
);
    localparam int HDR   = 1 + ADDR_W + SEL_W;
    localparam int CNT_W = $clog2(HDR + 1);
    localparam logic [CNT_W-1:0] LAST_POS  = CNT_W'(HDR - 1);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W);

    logic [CNT_W-1:0] pos;
    logic             active;
    logic             in_addr;
    logic             in_sel;

    // Track the bit position inside the header of the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos    <= '0;
            active <= 1'b0;
        end else if (frame_start) begin
            pos    <= CNT_W'(1);
            active <= 1'b1;
        end else if (active) begin
            pos <= pos + 1'b1;
            if (pos == LAST_POS) active <= 1'b0;
        end
    end

    // Decode which header field the current bit belongs to.
    always_comb begin
        in_addr  = active && !frame_start && (pos >= CNT_W'(1)) && (pos <= ADDR_LAST);
        in_sel   = active && !frame_start && (pos > ADDR_LAST);
        hdr_last = active && !frame_start && (pos == LAST_POS);
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic             pres_q;
        logic             zero_q;
        logic [SEL_W-1:0] sel_q;

        // Per-row serial state machine: presence, address zero test, select shift.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pres_q <= 1'b0;
                zero_q <= 1'b0;
                sel_q  <= '0;
            end else if (frame_start) begin
                pres_q <= row_in[r];
                zero_q <= 1'b1;
                sel_q  <= '0;
            end else if (in_addr) begin
                zero_q <= zero_q & ~row_in[r];
            end else if (in_sel) begin
                sel_q <= (sel_q << 1) | SEL_W'(row_in[r]);
            end
        end

        assign hit[r]      = pres_q & zero_q;
        assign sel_full[r] = (sel_q << 1) | SEL_W'(row_in[r]);
    end
endmodule

// File: rtl/ej_delay_line.sv
`timescale 1ns/1ps
// Module: fixed serial delay of one row.
// The bit sampled at an edge appears on bit_out DEPTH edges later.
// Assumes DEPTH >= 2.
module ej_delay_line #(
    parameter int DEPTH = 17
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    output logic bit_out
);
    logic [DEPTH-1:0] sr;

    // Shift the row stream one stage per bit-time.
    always_ff @(posedge clk) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[DEPTH-2:0], bit_in};
    end

    assign bit_out = sr[DEPTH-1];
endmodule

// File: rtl/ej_route_sel.sv
`timescale 1ns/1ps
// Module: latches the switch setting of each round.
// At the last header bit it records which rows are delivered and their
// processor indices. In single-eject mode only the lowest qualifying row is
// kept. The setting holds until the next header completes.
module ej_route_sel #(
    parameter int ROWS  = 7,
    parameter int SEL_W = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        hdr_last,
    input  logic                        one_eject,
    input  logic [ROWS-1:0]             hit,
    input  logic [ROWS-1:0][SEL_W-1:0]  sel_full,
    output logic [ROWS-1:0]             deliver,
    output logic [ROWS-1:0][SEL_W-1:0]  dest
);
    logic [ROWS-1:0] first_hit;

    // Isolate the lowest-numbered qualifying row.
    always_comb first_hit = hit & (~hit + ROWS'(1));

    // Capture the round's switch setting at the end of the header.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            deliver <= '0;
            dest    <= '0;
        end else if (hdr_last) begin
            deliver <= one_eject ? first_hit : hit;
            dest    <= sel_full;
        end
    end
endmodule

// File: rtl/ej_xbar.sv
`timescale 1ns/1ps
// Module: combinational crossbar with OR merging.
// Each delivered row's delayed bit is ORed onto its selected processor output.
// Rows that are not delivered go to their buffer output. Delivered rows send 0 there.
// Assumes PROCS equals 2**SEL_W.
module ej_xbar #(
    parameter int ROWS  = 7,
    parameter int PROCS = 16,
    parameter int SEL_W = 4
) (
    input  logic [ROWS-1:0]             tail,
    input  logic [ROWS-1:0]             deliver,
    input  logic [ROWS-1:0][SEL_W-1:0]  dest,
    output logic [PROCS-1:0]            proc_out,
    output logic [ROWS-1:0]             buf_out
);
    for (genvar p = 0; p < PROCS; p++) begin : g_proc
        logic [ROWS-1:0] mine;

        // Gather the delivered rows that target processor p.
        always_comb begin
            for (int r = 0; r < ROWS; r++)
                mine[r] = deliver[r] && (dest[r] == SEL_W'(p)) && tail[r];
        end

        assign proc_out[p] = |mine;
    end

    assign buf_out = tail & ~deliver;
endmodule

// File: rtl/ej_eject_xbar.sv
`timescale 1ns/1ps
// Module: destination-detect ejection crossbar (top).
// Parses each row's header serially, delays every row by one header length,
// and switches arrived messages to processors. Other rows go to the buffers.
// Assumes frame_start comes at least one header length apart.
module ej_eject_xbar #(
    parameter int ROWS   = ej_pkg::EJ_ROWS,
    parameter int PROCS  = ej_pkg::EJ_PROCS,
    parameter int ADDR_W = ej_pkg::EJ_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              one_eject,
    input  logic [ROWS-1:0]   row_in,
    output logic [PROCS-1:0]  proc_out,
    output logic [ROWS-1:0]   buf_out
);
    localparam int SEL_W = $clog2(PROCS);
    localparam int HDR   = ej_pkg::hdr_bits(ADDR_W, PROCS);

    logic                       hdr_last;
    logic [ROWS-1:0]            hit;
    logic [ROWS-1:0][SEL_W-1:0] sel_full;
    logic [ROWS-1:0]            deliver;
    logic [ROWS-1:0][SEL_W-1:0] dest;
    logic [ROWS-1:0]            tail;

    ej_hdr_parse #(.ROWS(ROWS), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_parse (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .row_in(row_in),
        .hdr_last(hdr_last), .hit(hit), .sel_full(sel_full)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_dly
        ej_delay_line #(.DEPTH(HDR)) u_dly (
            .clk(clk), .rst_n(rst_n), .bit_in(row_in[r]), .bit_out(tail[r])
        );
    end

    ej_route_sel #(.ROWS(ROWS), .SEL_W(SEL_W)) u_route (
        .clk(clk), .rst_n(rst_n), .hdr_last(hdr_last), .one_eject(one_eject),
        .hit(hit), .sel_full(sel_full), .deliver(deliver), .dest(dest)
    );

    ej_xbar #(.ROWS(ROWS), .PROCS(PROCS), .SEL_W(SEL_W)) u_xbar (
        .tail(tail), .deliver(deliver), .dest(dest),
        .proc_out(proc_out), .buf_out(buf_out)
    );
endmodule

// File: rtl/ej_eject_xbar_chk.sv
`timescale 1ns/1ps
// Module: assertion checker bound to ej_eject_xbar.
module ej_eject_xbar_chk #(
    parameter int ROWS  = 7,
    parameter int PROCS = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             one_eject,
    input logic             hdr_last,
    input logic [ROWS-1:0]  hit,
    input logic [ROWS-1:0]  deliver,
    input logic [PROCS-1:0] proc_out,
    input logic [ROWS-1:0]  buf_out
);
    // R1: outputs are quiet in the first cycle after reset.
    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (proc_out == '0 && buf_out == '0));

    // R6: single-eject round delivers at most one row.
    p_single_eject_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_last && one_eject) |=> $onehot0(deliver));

    // R9: switch setting holds between header ends.
    p_setting_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_last |=> $stable(deliver));

    // R4: a processor output is only active while some row is delivered.
    p_proc_needs_delivery_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_out != '0) |-> (deliver != '0));

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        // R3: a row failing the arrival test is never delivered.
        p_no_false_arrival_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (hdr_last && !hit[r]) |=> !deliver[r]);
    end
endmodule

bind ej_eject_xbar ej_eject_xbar_chk #(.ROWS(ROWS), .PROCS(PROCS)) u_chk (
    .clk(clk), .rst_n(rst_n), .one_eject(one_eject), .hdr_last(hdr_last),
    .hit(hit), .deliver(deliver), .proc_out(proc_out), .buf_out(buf_out)
);

// File: tb/tb_ej_eject_xbar.sv
`timescale 1ns/1ps
module tb_ej_eject_xbar;
    localparam int ROWS = 7;
    localparam int PROCS = 16;
    localparam int HDR = 17;
    localparam int NCYC = 2400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_start = 1'b0;
    logic one_eject = 1'b0;
    logic [ROWS-1:0] row_in = '0;
    logic [PROCS-1:0] proc_out;
    logic [ROWS-1:0] buf_out;

    int checks = 0;
    int errors = 0;

    // Stimulus history and per-frame expectations.
    logic [ROWS-1:0] rin [NCYC];
    logic fs [NCYC];
    logic oe [NCYC];
    int fstart_of [NCYC];
    logic [ROWS-1:0] dlv [NCYC];
    logic [3:0] dsel [NCYC][ROWS];
    logic [ROWS-1:0] f_pres;
    logic [11:0] f_addr [ROWS];
    logic [3:0] f_sel [ROWS];
    int tp = 5;
    int last_f = -1;

    ej_eject_xbar dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .one_eject(one_eject),
        .row_in(row_in), .proc_out(proc_out), .buf_out(buf_out)
    );

    always #5 clk = ~clk;

    // Append one frame built from the scratch fields.
    task automatic put_frame(input int len, input logic oe_v);
        int f0 = tp;
        fs[f0] = 1'b1;
        for (int i = 0; i < len; i++) begin
            for (int r = 0; r < ROWS; r++) begin
                if (i == 0) rin[f0+i][r] = f_pres[r];
                else if (i <= 12) rin[f0+i][r] = f_addr[r][i-1];
                else if (i <= 16) rin[f0+i][r] = f_sel[r][16-i];
                else rin[f0+i][r] = 1'($urandom % 2);
            end
            fstart_of[f0+i] = f0;
        end
        oe[f0+16] = oe_v;
        last_f = f0;
        tp = f0 + len;
    endtask

    // Expected delivery set and indices computed from the stored bits.
    task automatic compute_dec(input int f);
        logic [ROWS-1:0] q;
        q = '0;
        for (int r = 0; r < ROWS; r++) begin
            logic z = 1'b1;
            for (int i = 1; i <= 12; i++) if (rin[f+i][r]) z = 1'b0;
            q[r] = rin[f][r] & z;
            dsel[f][r] = {rin[f+13][r], rin[f+14][r], rin[f+15][r], rin[f+16][r]};
        end
        if (oe[f+16]) begin
            logic [ROWS-1:0] one = '0;
            for (int r = ROWS-1; r >= 0; r--) if (q[r]) one = '0 | (ROWS'(1) << r);
            q = one;
        end
        dlv[f] = q;
    endtask

    // Compare outputs seen at negedge t against the model.
    task automatic check_cycle(input int t);
        logic [PROCS-1:0] pexp = '0;
        logic [ROWS-1:0] bexp = '0;
        logic [ROWS-1:0] tl = '0;
        string ptag = "R7";
        string btag = "R7";
        int s = t - HDR;
        int f = -1;
        if (s >= 0) begin
            tl = rin[s];
            f = fstart_of[s];
        end
        if (f >= 0) begin
            bit coll = 0;
            bit miss = 0;
            for (int r = 0; r < ROWS; r++) begin
                if (dlv[f][r] && tl[r]) pexp[dsel[f][r]] = 1'b1;
                for (int k = r + 1; k < ROWS; k++)
                    if (dlv[f][r] && dlv[f][k] && dsel[f][r] == dsel[f][k]) coll = 1;
                if (rin[f][r] && !dlv[f][r]) miss = 1;
            end
            bexp = tl & ~dlv[f];
            if (oe[f+16]) ptag = "R6";
            else if (coll) ptag = "R5";
            else if (t == f + HDR) ptag = "R2";
            else if (t >= f + 2*HDR) ptag = "R9";
            else ptag = "R4";
            if (dlv[f] != '0) btag = "R8";
            else if (miss) btag = "R3";
        end else begin
            bexp = tl;
        end
        checks++;
        if (proc_out !== pexp) begin
            errors++;
            $display("FAIL %s proc_out cycle %0d: got %h expected %h", ptag, t, proc_out, pexp);
        end
        checks++;
        if (buf_out !== bexp) begin
            errors++;
            $display("FAIL %s buf_out cycle %0d: got %h expected %h", btag, t, buf_out, bexp);
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < NCYC; i++) begin
            rin[i] = '0; fs[i] = 1'b0; oe[i] = 1'($urandom % 2);
            fstart_of[i] = -1; dlv[i] = '0;
        end
        // Directed: each row to a distinct processor (R4).
        for (int r = 0; r < ROWS; r++) begin
            f_pres[r] = 1'b1; f_addr[r] = '0; f_sel[r] = 4'(r * 2 + 1);
        end
        put_frame(30, 1'b0);
        // Directed: all rows to processor 5, OR merge (R5).
        for (int r = 0; r < ROWS; r++) f_sel[r] = 4'd5;
        put_frame(30, 1'b0);
        // Directed: single eject with row 0 empty, row 1 wins (R6).
        f_pres = 7'b1111110;
        for (int r = 0; r < ROWS; r++) f_sel[r] = 4'd9;
        put_frame(25, 1'b1);
        // Directed: one address bit set per row, nobody arrives (R3).
        f_pres = '1;
        for (int r = 0; r < ROWS; r++) f_addr[r] = 12'(1) << (r == ROWS-1 ? 11 : r);
        put_frame(20, 1'b0);
        // Random frames.
        while (tp + 60 < NCYC - 40) begin
            for (int r = 0; r < ROWS; r++) begin
                int pick = $urandom % 3;
                f_pres[r] = 1'(($urandom % 4) != 0);
                f_addr[r] = (pick == 0) ? 12'd0 : (pick == 1) ? (12'(1) << ($urandom % 12)) : 12'($urandom);
                f_sel[r] = (($urandom % 2) != 0) ? 4'($urandom % 4) : 4'($urandom);
            end
            put_frame(17 + ($urandom % 24), 1'(($urandom % 4) == 0));
        end
        for (int i = tp; i < NCYC; i++) fstart_of[i] = last_f;
        for (int i = 0; i < NCYC; i++) if (fs[i]) compute_dec(i);

        repeat (3) @(negedge clk);
        checks++;
        if (proc_out !== '0 || buf_out !== '0) begin
            errors++;
            $display("FAIL R1 outputs in reset: got %h/%h expected 0/0", proc_out, buf_out);
        end
        rst_n = 1'b1;
        for (int t = 0; t < NCYC; t++) begin
            @(negedge clk);
            check_cycle(t);
            row_in = rin[t];
            frame_start = fs[t];
            one_eject = oe[t];
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(100000 * 10);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule